// File: doc/BRIEF.md
# Serial Addressed Register Loader

This block takes 12-bit words sent by a host controller over a two-line serial link, one line carrying bits and the other a bit clock, and places each word's 8-bit value into one of sixteen 8-bit registers inside the block. The block has no select line. A word is framed only by counting bit-clock rising edges and by a commit event: a rising edge on the data line while the bit clock is high. Outside that event the data line is expected to hold steady during the clock-high phase.

Both serial lines are asynchronous to the fast system clock. Each line passes through its own multi-stage synchronizer before edge detection. A commit writes the selected register and raises a one-cycle write strobe that carries the address and value just written. A commit made after any bit count other than twelve drops the word. Every commit clears the bit counter, so the next word starts from bit zero.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset, all sixteen registers read zero and the write strobe is low.
- R2: The first eight bits of a word, least significant first, form the value. The next four bits, least significant first, form the register address.
- R3: A register changes only on a commit event, which is a rising edge on the data line while the bit clock is already high. Twelve shifted bits without a commit leave every register unchanged.
- R4: A commit after fewer than twelve bits writes nothing and raises no strobe.
- R5: A commit after more than twelve bits writes nothing and raises no strobe.
- R6: Every commit, kept or dropped, clears the bit counter, so a correct word right after it is accepted.
- R7: Each accepted word raises the write strobe for exactly one system cycle, together with its address and value. In that same cycle the addressed register already holds the value.
- R8: An accepted word changes only the addressed register.
- R9: When the data line and the bit clock rise in the same synchronized sample, the event counts as a bit of value one and not as a commit.
- R10: Data-line changes while the bit clock is low, and a falling data line while the clock is high, shift nothing and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data line, asynchronous |
| regs_o | output | 128 | Register contents, register i at bits [8i+7:8i] |
| wr_stb_o | output | 1 | One-cycle pulse for each accepted word |
| wr_addr_o | output | 4 | Address of the register written |
| wr_data_o | output | 8 | Value written |

## Verification
Bit capture and commit detection both watch the data line. They meet in one synchronized sample when the data line rises together with the bit clock. The bench provokes this by raising both lines in the same time step after eleven bits. It then expects no strobe and no register change. A later drop and rise of the data line while the clock stays high must commit a word whose last address bit is one. The scoreboard judges the result by the strobe's address and value and by the full register contents.

// File: rtl/serload_pkg.sv
package serload_pkg;
   // synchronized view of one serial line
   typedef struct packed {
      logic level;
      logic rise;
   } line_evt_t;
endpackage

// File: rtl/line_sync.sv
module line_sync
   import serload_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      line_i,
   output line_evt_t evt_o
);
   logic [STAGES-1:0] chain;
   logic              last;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= line_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];

   always_comb begin
      evt_o.level = chain[STAGES-1];
      evt_o.rise  = chain[STAGES-1] & ~last;
   end
endmodule

// File: rtl/word_shifter.sv
module word_shifter
   import serload_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_evt_t         sclk_i,
   input  line_evt_t         sdat_i,
   output logic              commit_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int WORD_W = DATA_W + ADDR_W;
   localparam int CNT_W  = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  count;
   logic              take_bit;
   logic              xfer;

   always_comb begin
      take_bit = sclk_i.rise;
      // clock was already high before this data rise
      xfer     = sdat_i.rise & sclk_i.level & ~sclk_i.rise;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         shreg    <= '0;
         count    <= '0;
         commit_o <= 1'b0;
         addr_o   <= '0;
         data_o   <= '0;
      end else begin
         commit_o <= 1'b0;
         if (xfer) begin
            count <= '0;
            if (count == FULL) begin
               commit_o <= 1'b1;
               data_o   <= shreg[DATA_W-1:0];
               addr_o   <= shreg[WORD_W-1:DATA_W];
            end
         end else if (take_bit) begin
            shreg <= {sdat_i.level, shreg[WORD_W-1:1]};
            if (count != OVER) count <= count + 1'b1;
         end
      end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             commit_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DATA_W-1:0]                data_i,
   output logic [(1<<ADDR_W)*DATA_W-1:0]    regs_o,
   output logic                             wr_stb_o,
   output logic [ADDR_W-1:0]                wr_addr_o,
   output logic [DATA_W-1:0]                wr_data_o
);
   localparam int NUM_REGS = 1 << ADDR_W;

   genvar i;
   generate
      for (i = 0; i < NUM_REGS; i++) begin : g_reg
         logic hit;
         always_comb hit = commit_i && (addr_i == ADDR_W'(i));
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)   regs_o[i*DATA_W +: DATA_W] <= '0;
            else if (hit) regs_o[i*DATA_W +: DATA_W] <= data_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wr_stb_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_stb_o <= commit_i;
         if (commit_i) begin
            wr_addr_o <= addr_i;
            wr_data_o <= data_i;
         end
      end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
   import serload_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ser_clk_i,
   input  logic                          ser_dat_i,
   output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
   output logic                          wr_stb_o,
   output logic [ADDR_W-1:0]             wr_addr_o,
   output logic [DATA_W-1:0]             wr_data_o
);
   generate
      if (DATA_W < 1 || ADDR_W < 1 || ADDR_W > 8 || SYNC_STAGES < 2) begin : g_bad_cfg
         $error("serial_reg_loader: unsupported parameter set");
      end
   endgenerate

   line_evt_t         sclk_evt, sdat_evt;
   logic              commit;
   logic [ADDR_W-1:0] c_addr;
   logic [DATA_W-1:0] c_data;

   line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .line_i(ser_clk_i), .evt_o(sclk_evt));
   line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .line_i(ser_dat_i), .evt_o(sdat_evt));

   word_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_evt), .sdat_i(sdat_evt),
      .commit_o(commit), .addr_o(c_addr), .data_o(c_data));

   reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .addr_i(c_addr),
      .data_i(c_data), .regs_o(regs_o), .wr_stb_o(wr_stb_o),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o));
endmodule

// File: rtl/serial_reg_loader_checker.sv
module serial_reg_loader_checker #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
   input logic                          wr_stb_o,
   input logic [ADDR_W-1:0]             wr_addr_o,
   input logic [DATA_W-1:0]             wr_data_o
);
   localparam int NUM_REGS = 1 << ADDR_W;

   AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o); // R7

   AST_NO_WRITE_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_o |-> $stable(regs_o)); // R3

   genvar i;
   generate
      for (i = 0; i < NUM_REGS; i++) begin : g_chk
         AST_STB_MATCHES_REG: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb_o && wr_addr_o == ADDR_W'(i)) |->
               (regs_o[i*DATA_W +: DATA_W] == wr_data_o)); // R7
         AST_OTHER_REGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb_o && wr_addr_o != ADDR_W'(i)) |->
               $stable(regs_o[i*DATA_W +: DATA_W])); // R8
      end
   endgenerate
endmodule

bind serial_reg_loader serial_reg_loader_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_checker (
   .clk(clk), .rst_n(rst_n), .regs_o(regs_o), .wr_stb_o(wr_stb_o),
   .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o));

// File: tb/serial_reg_loader_bench.sv
module serial_reg_loader_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;     // system cycles per serial phase
   localparam int DW = 8;
   localparam int AW = 4;
   localparam int NR = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic sdat = 1'b0;
   logic [NR*DW-1:0] regs;
   logic          stb;
   logic [AW-1:0] waddr;
   logic [DW-1:0] wdata;

   int checks = 0;
   int fails  = 0;
   int strobes_seen = 0;
   int strobes_expected = 0;
   bit mon_on = 1'b0;
   bit prev_stb = 1'b0;
   bit done = 1'b0;

   logic [AW+DW-1:0] exp_q[$];
   logic [DW-1:0]    model [NR];

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_reg_loader u_serial_reg_loader (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
      .regs_o(regs), .wr_stb_o(stb), .wr_addr_o(waddr), .wr_data_o(wdata));

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      int bad = -1;
      for (int i = 0; i < NR; i++)
         if (regs[i*DW +: DW] !== model[i] && bad < 0) bad = i;
      if (bad < 0) chk(1'b1, req, "register bank", 0, 0);
      else chk(1'b0, req, $sformatf("register %0d", bad),
               int'(regs[bad*DW +: DW]), int'(model[bad]));
   endtask

   // shift n bits of word, LSB first; clock is left high after the last bit
   task automatic send_bits(input logic [AW+DW-1:0] w, input int n, input bit glitch);
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0;
         if (glitch) begin
            sdat = ~sdat; wait_cyc(HALF);
            sdat = ~sdat; wait_cyc(HALF);
         end
         sdat = (i < AW+DW) ? w[i] : 1'b0;
         wait_cyc(HALF);
         sclk = 1'b1;
         wait_cyc(HALF);
      end
   endtask

   // commit event while clock is high, then return to idle
   task automatic fire();
      if (sdat) begin
         sdat = 1'b0;              // falling while clock high: ignored (R10)
         wait_cyc(HALF);
      end
      sdat = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
      wait_cyc(HALF);
      sdat = 1'b0;
      wait_cyc(HALF);
   endtask

   task automatic expect_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_q.push_back({a, d});
      model[a] = d;
      strobes_expected++;
   endtask

   task automatic good_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit glitch);
      send_bits({a, d}, AW+DW, glitch);
      expect_write(a, d);
      fire();
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (mon_on) begin
         if (prev_stb && stb)
            chk(1'b0, "R7", "strobe wider than one cycle", 2, 1);
         if (stb) begin
            strobes_seen++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3", $sformatf("unexpected write to %0d", waddr), int'(wdata), 0);
            end else begin
               logic [AW+DW-1:0] e;
               e = exp_q.pop_front();
               chk(waddr === e[AW+DW-1:DW], "R2", "strobe address", int'(waddr), int'(e[AW+DW-1:DW]));
               chk(wdata === e[DW-1:0], "R2", "strobe value", int'(wdata), int'(e[DW-1:0]));
               chk(regs[waddr*DW +: DW] === wdata, "R7", "register at strobe",
                   int'(regs[waddr*DW +: DW]), int'(wdata));
            end
         end
      end
      prev_stb = stb;
   end

   initial begin
      for (int i = 0; i < NR; i++) model[i] = '0;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(2);
      // R1: reset state
      check_regs("R1");
      chk(stb === 1'b0, "R1", "strobe after reset", int'(stb), 0);
      mon_on = 1'b1;

      // R3: twelve bits, no commit yet
      send_bits({4'd3, 8'hA5}, AW+DW, 1'b0);
      wait_cyc(HALF);
      check_regs("R3");
      expect_write(4'd3, 8'hA5);
      fire();
      check_regs("R2");

      // R8 and R2: several patterns and both end addresses
      good_word(4'd0, 8'h01, 1'b0);
      good_word(4'd15, 8'h80, 1'b0);
      good_word(4'd7, 8'h3C, 1'b0);
      good_word(4'd9, 8'hFF, 1'b0);
      check_regs("R8");

      // R4 then R6
      send_bits({4'd5, 8'h55}, AW+DW-1, 1'b0);
      fire();
      check_regs("R4");
      good_word(4'd5, 8'hC3, 1'b0);
      check_regs("R6");

      // R5 then R6
      send_bits({4'd6, 8'h66}, AW+DW+1, 1'b0);
      fire();
      check_regs("R5");
      good_word(4'd6, 8'h99, 1'b0);
      check_regs("R6");

      // R10: toggles while the clock is low
      good_word(4'd12, 8'h5A, 1'b1);
      check_regs("R10");

      // R9: data and clock rise together on the twelfth bit (A3 = 1)
      send_bits({4'b1010, 8'h27}, AW+DW-1, 1'b0);
      sclk = 1'b0;
      sdat = 1'b0;
      wait_cyc(HALF);
      sclk = 1'b1;
      sdat = 1'b1;
      wait_cyc(HALF);
      check_regs("R9");
      expect_write(4'b1010, 8'h27);
      fire();
      check_regs("R9");

      wait_cyc(4);
      chk(exp_q.size() == 0, "R7", "pending expected writes", exp_q.size(), 0);
      chk(strobes_seen == strobes_expected, "R7", "strobe count",
          strobes_seen, strobes_expected);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            chk(1'b0, "R1", "watchdog expired", 0, 1);
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule